// File: doc/BRIEF.md
# SM4 Four-Round Cipher Step

This block moves a 128-bit SM4 cipher state forward by four rounds in one accepted beat. The state group holds four 32-bit words. The key group holds four 32-bit round keys. The block returns the four newest state words, which the next operation takes as its input state. Eight operations in a row, each fed the next four scheduled round keys, make up a full 32-round encryption. The caller reads the four result words in descending index order to get the ciphertext. The key expansion, the sequencing over eight operations and the final word reversal stay with the caller.

The round keys can come from two places. In per-group mode every state beat carries its own key group. In broadcast mode a key-load strobe copies one key group into an internal register, and every later state beat uses that stored key while its own key field is ignored. The issue logic decides whether a configuration is legal: 32-bit elements, 128-bit groups, start index and length aligned to four elements, and no destination/key register overlap in broadcast mode. It reports the result on one input. When that input flags a bad configuration, beats are taken in and discarded, and a sticky error flag goes up.

Both the input and the output use a valid/ready stream with a last marker. The result sits behind one output register.

Top module: `sm4r_round4`

## Requirements
- R1: State, key and result groups hold word i in bits 32i+31:32i, with word 0 in bits 31:0. Eight chained operations on the standard SM4 test plaintext 0123456789abcdeffedcba9876543210, keyed by the standard key schedule of that same 128-bit key, give a result group equal to 128'h681edf34d206965e86b3e94f536e4246.
- R2: For i = 0..3 in sequence, word x[i+4] = x[i] ^ L(T(x[i+1] ^ x[i+2] ^ x[i+3] ^ k[i])). Here L(s) = s ^ rotl(s,2) ^ rotl(s,10) ^ rotl(s,18) ^ rotl(s,24). T applies the S-box to each byte in place. S(b) = A(inv(A(b))), where A(v) = v ^ rotr(v,1) ^ rotr(v,2) ^ rotr(v,5) ^ rotr(v,7) ^ 8'hD3, and inv is the inverse in GF(2^8) modulo x^8+x^7+x^6+x^5+x^4+x^2+1, with inv(0) = 0. The output group is {x7,x6,x5,x4}.
- R3: With modeBcast = 0, each beat uses the inKey value presented with that beat.
- R4: With modeBcast = 1, every beat uses the key group stored by the most recent legal keyLoad, and inKey has no effect. A later legal keyLoad replaces the stored key for all beats after it.
- R5: inReady is 0 in every cycle in which keyLoad is 1.
- R6: Outside a keyLoad cycle, inReady = !outValid || outReady. After a legal beat is accepted, outValid is 1 in the next cycle, and outValid never rises without such a beat.
- R7: While outValid = 1 and outReady = 0, outValid, outState and outLast hold their values into the next cycle.
- R8: outLast of a result equals inLast of the beat that produced it.
- R9: A beat accepted while cfgIllegal = 1 produces no output beat.
- R10: errFlag rises in the cycle after an accepted beat or a keyLoad while cfgIllegal = 1, and then stays high until reset. A keyLoad while cfgIllegal = 1 leaves the stored key unchanged.
- R11: During and right after reset, outValid, outLast and errFlag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeBcast | input | 1 | 1: stored key group, 0: key group carried with each beat |
| cfgIllegal | input | 1 | Current configuration is illegal |
| keyLoad | input | 1 | Store keyIn as the broadcast key |
| keyIn | input | 128 | Key group for keyLoad |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Input beat accepted when high with inValid |
| inState | input | 128 | Input state words x0..x3 |
| inKey | input | 128 | Per-beat round keys k0..k3 |
| inLast | input | 1 | Last beat of a stream |
| outValid | output | 1 | Result beat valid |
| outReady | input | 1 | Consumer takes the result |
| outState | output | 128 | Result words x4..x7 |
| outLast | output | 1 | Last marker of the result |
| errFlag | output | 1 | Sticky illegal-configuration flag |

## Verification
The assertions cover the handshake rules on every cycle. They check that the input is blocked during key loads, that a result follows an accepted legal beat, and that a stalled result holds steady. They also check that the last marker follows its beat, that illegal beats are dropped, and that the error flag stays set once raised. Only the bench scenarios can show that the arithmetic is right. For that it chains eight operations to the published ciphertext, streams random states under backpressure against a field-arithmetic model, and confirms that broadcast mode ignores the per-beat key. It also shows that an illegal key load leaves the stored key in place.

// File: rtl/sm4r_pkg.sv
package sm4r_pkg;
  localparam int WORD_W  = 32;
  localparam int LANES   = 4;
  localparam int GROUP_W = WORD_W * LANES;
  localparam int BYTE_W  = 8;
  localparam int BYTES   = WORD_W / BYTE_W;
  localparam logic [BYTE_W-1:0] FIELD_RED = 8'hF5;
  localparam logic [BYTE_W-1:0] AFF_CONST = 8'hD3;

  typedef logic [WORD_W-1:0]  word_t;
  typedef logic [GROUP_W-1:0] group_t;
  typedef logic [BYTE_W-1:0]  byte_t;

  typedef struct packed {
    logic keyCapture;
    logic resultLoad;
  } ctrlStrobe_t;

  function automatic byte_t gfMul(byte_t a, byte_t b);
    byte_t acc = '0;
    byte_t sh = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[BYTE_W-1] ? ({sh[BYTE_W-2:0], 1'b0} ^ FIELD_RED) : {sh[BYTE_W-2:0], 1'b0};
    end
    return acc;
  endfunction

  // a^254 by repeated squaring; maps zero to zero
  function automatic byte_t gfInv(byte_t a);
    byte_t sq = a;
    byte_t acc = 8'h01;
    for (int i = 1; i < BYTE_W; i++) begin
      sq  = gfMul(sq, sq);
      acc = gfMul(acc, sq);
    end
    return acc;
  endfunction

  function automatic byte_t affineMap(byte_t v);
    return v ^ {v[0], v[7:1]} ^ {v[1:0], v[7:2]} ^ {v[4:0], v[7:5]} ^ {v[6:0], v[7]} ^ AFF_CONST;
  endfunction

  function automatic byte_t sboxCalc(byte_t b);
    return affineMap(gfInv(affineMap(b)));
  endfunction

  function automatic word_t rotl32(word_t w, int n);
    return (w << n) | (w >> (WORD_W - n));
  endfunction

  function automatic word_t tauSub(word_t w);
    word_t r;
    for (int i = 0; i < BYTES; i++) r[i*BYTE_W +: BYTE_W] = sboxCalc(w[i*BYTE_W +: BYTE_W]);
    return r;
  endfunction

  function automatic word_t linMix(word_t s);
    return s ^ rotl32(s, 2) ^ rotl32(s, 10) ^ rotl32(s, 18) ^ rotl32(s, 24);
  endfunction
endpackage

// File: rtl/sm4r_ctrl.sv
module sm4r_ctrl
  import sm4r_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        keyLoad,
  input  logic        cfgIllegal,
  input  logic        inValid,
  input  logic        outReady,
  output logic        inReady,
  output logic        outValid,
  output logic        errFlag,
  output ctrlStrobe_t strobe
);
  logic beatTake;

  always_comb begin
    inReady           = !keyLoad && (!outValid || outReady);
    beatTake          = inValid && inReady;
    strobe.keyCapture = keyLoad && !cfgIllegal;
    strobe.resultLoad = beatTake && !cfgIllegal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      if (strobe.resultLoad) outValid <= 1'b1;
      else if (outReady)     outValid <= 1'b0;
      if (cfgIllegal && (keyLoad || beatTake)) errFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/sm4r_dpath.sv
module sm4r_dpath
  import sm4r_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic        modeBcast,
  input  group_t      keyIn,
  input  group_t      inState,
  input  group_t      inKey,
  input  logic        inLast,
  output group_t      outState,
  output logic        outLast
);
  localparam int CHAIN = 2 * LANES;

  group_t keyReg;
  group_t keySel;
  group_t resultNext;
  word_t  rk [LANES];
  word_t  xw [CHAIN];

  assign keySel = modeBcast ? keyReg : inKey;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rk[g] = keySel[g*WORD_W +: WORD_W];
    assign resultNext[g*WORD_W +: WORD_W] = xw[g + LANES];
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) xw[i] = inState[i*WORD_W +: WORD_W];
    for (int i = 0; i < LANES; i++)
      xw[i + LANES] = xw[i] ^ linMix(tauSub(xw[i+1] ^ xw[i+2] ^ xw[i+3] ^ rk[i]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyReg   <= '0;
      outState <= '0;
      outLast  <= 1'b0;
    end else begin
      if (strobe.keyCapture) keyReg <= keyIn;
      if (strobe.resultLoad) begin
        outState <= resultNext;
        outLast  <= inLast;
      end
    end
  end
endmodule

// File: rtl/sm4r_round4.sv
module sm4r_round4
  import sm4r_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeBcast,
  input  logic               cfgIllegal,
  input  logic               keyLoad,
  input  logic [GROUP_W-1:0] keyIn,
  input  logic               inValid,
  output logic               inReady,
  input  logic [GROUP_W-1:0] inState,
  input  logic [GROUP_W-1:0] inKey,
  input  logic               inLast,
  output logic               outValid,
  input  logic               outReady,
  output logic [GROUP_W-1:0] outState,
  output logic               outLast,
  output logic               errFlag
);
  ctrlStrobe_t strobe;

  sm4r_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .keyLoad(keyLoad), .cfgIllegal(cfgIllegal),
    .inValid(inValid), .outReady(outReady), .inReady(inReady),
    .outValid(outValid), .errFlag(errFlag), .strobe(strobe)
  );

  sm4r_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .modeBcast(modeBcast),
    .keyIn(keyIn), .inState(inState), .inKey(inKey), .inLast(inLast),
    .outState(outState), .outLast(outLast)
  );
endmodule

// File: rtl/sm4r_round4_chk.sv
module sm4r_round4_chk
  import sm4r_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               modeBcast,
  input logic               cfgIllegal,
  input logic               keyLoad,
  input logic [GROUP_W-1:0] keyIn,
  input logic               inValid,
  input logic               inReady,
  input logic [GROUP_W-1:0] inState,
  input logic [GROUP_W-1:0] inKey,
  input logic               inLast,
  input logic               outValid,
  input logic               outReady,
  input logic [GROUP_W-1:0] outState,
  input logic               outLast,
  input logic               errFlag
);
  a_r5_key_load_blocks: assert property (@(posedge clk) disable iff (!rstN)
    keyLoad |-> !inReady);

  a_r6_ready_when_free: assert property (@(posedge clk) disable iff (!rstN)
    (!outValid && !keyLoad) |-> inReady);

  a_r6_result_follows: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && !cfgIllegal) |=> outValid);

  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    (!outValid && !(inValid && inReady && !cfgIllegal)) |=> !outValid);

  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outState) && $stable(outLast)));

  a_r8_last_tracks: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && !cfgIllegal) |=> (outLast == $past(inLast)));

  a_r9_illegal_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && cfgIllegal) |=> !outValid);

  a_r10_err_raise: assert property (@(posedge clk) disable iff (!rstN)
    (cfgIllegal && (keyLoad || (inValid && inReady))) |=> errFlag);

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);
endmodule

bind sm4r_round4 sm4r_round4_chk u_chk (.*);

// File: tb/sm4r_round4_bench.sv
module sm4r_round4_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;
  localparam int QMAX = 128;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         modeBcast = 1'b0;
  logic         cfgIllegal = 1'b0;
  logic         keyLoad = 1'b0;
  logic [127:0] keyIn = '0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [127:0] inState = '0;
  logic [127:0] inKey = '0;
  logic         inLast = 1'b0;
  logic         outValid;
  logic         outReady = 1'b0;
  logic [127:0] outState;
  logic         outLast;
  logic         errFlag;

  int checks = 0;
  int errors = 0;

  always #(HALF) clk = ~clk;

  sm4r_round4 u_sm4r_round4 (
    .clk(clk), .rstN(rstN), .modeBcast(modeBcast), .cfgIllegal(cfgIllegal),
    .keyLoad(keyLoad), .keyIn(keyIn), .inValid(inValid), .inReady(inReady),
    .inState(inState), .inKey(inKey), .inLast(inLast), .outValid(outValid),
    .outReady(outReady), .outState(outState), .outLast(outLast), .errFlag(errFlag)
  );

  // ---------------- reference arithmetic ----------------
  logic [7:0]  sboxT [256];
  logic [31:0] rkSched [32];
  logic [31:0] seed = 32'h1234_5678;

  function automatic logic [7:0] bMul(logic [7:0] a, logic [7:0] b);
    logic [7:0] p = 8'h00;
    logic [7:0] aa = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ aa;
      aa = aa[7] ? ((aa << 1) ^ 8'hF5) : (aa << 1);
    end
    return p;
  endfunction

  function automatic logic [7:0] bAff(logic [7:0] x);
    logic [7:0] y;
    logic [7:0] c = 8'hD3;
    for (int i = 0; i < 8; i++)
      y[i] = x[i] ^ x[(i+1)%8] ^ x[(i+2)%8] ^ x[(i+5)%8] ^ x[(i+7)%8] ^ c[i];
    return y;
  endfunction

  function automatic logic [31:0] rol(logic [31:0] v, int n);
    return (v << n) | (v >> (32 - n));
  endfunction

  function automatic logic [31:0] tauB(logic [31:0] w);
    return {sboxT[w[31:24]], sboxT[w[23:16]], sboxT[w[15:8]], sboxT[w[7:0]]};
  endfunction

  function automatic logic [127:0] refRound4(logic [127:0] st, logic [127:0] key);
    logic [31:0] x [8];
    logic [31:0] s;
    for (int i = 0; i < 4; i++) x[i] = st[32*i +: 32];
    for (int i = 0; i < 4; i++) begin
      s = tauB(x[i+1] ^ x[i+2] ^ x[i+3] ^ key[32*i +: 32]);
      x[i+4] = x[i] ^ s ^ rol(s, 2) ^ rol(s, 10) ^ rol(s, 18) ^ rol(s, 24);
    end
    return {x[7], x[6], x[5], x[4]};
  endfunction

  function automatic logic [31:0] rnd32();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic logic [127:0] rnd128();
    logic [127:0] v;
    for (int i = 0; i < 4; i++) v[32*i +: 32] = rnd32();
    return v;
  endfunction

  // ---------------- checking machinery ----------------
  logic [127:0] expData [QMAX];
  logic         expLast [QMAX];
  string        expTag  [QMAX];
  int           wrIdx = 0;
  int           rdIdx = 0;
  logic [127:0] bKey = '0;
  logic [127:0] lastPop = '0;
  bit           lastAcc = 0;
  bit           expectValid = 0;
  bit           stallArmed = 0;
  logic [127:0] stallData = '0;
  logic         stallLast = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // inputs are set at a falling edge; sample just before the rising edge
  task automatic stepCycle();
    bit accNow;
    #(HALF - 1);
    if (keyLoad) check(inReady == 1'b0, "R5 inReady during keyLoad", 128'(inReady), 128'd0);
    if (stallArmed)
      check(outValid && outState == stallData && outLast == stallLast,
            "R7 stalled result changed", outState, stallData);
    stallArmed = outValid && !outReady;
    stallData  = outState;
    stallLast  = outLast;
    if (expectValid) check(outValid == 1'b1, "R6 result not valid after accept", 128'(outValid), 128'd1);
    expectValid = 0;
    if (outValid && outReady) begin
      if (rdIdx == wrIdx) begin
        check(1'b0, "R9 R6 unexpected output beat", outState, 128'd0);
      end else begin
        check(outState == expData[rdIdx], expTag[rdIdx], outState, expData[rdIdx]);
        check(outLast == expLast[rdIdx], "R8 outLast", 128'(outLast), 128'(expLast[rdIdx]));
        rdIdx++;
      end
      lastPop = outState;
    end
    accNow = inValid && inReady;
    if (accNow && !cfgIllegal) begin
      expData[wrIdx] = refRound4(inState, modeBcast ? bKey : inKey);
      expLast[wrIdx] = inLast;
      expTag[wrIdx]  = modeBcast ? "R4 broadcast result" : "R2 R3 per-group result";
      wrIdx++;
      expectValid = 1;
    end
    if (keyLoad && !cfgIllegal) bKey = keyIn;
    lastAcc = accNow;
    @(negedge clk);
  endtask

  task automatic sendBeat(input logic [127:0] st, input logic [127:0] key, input logic lst);
    inState = st;
    inKey   = key;
    inLast  = lst;
    inValid = 1'b1;
    do stepCycle(); while (!lastAcc);
    inValid = 1'b0;
  endtask

  task automatic drain();
    outReady = 1'b1;
    while (rdIdx != wrIdx) stepCycle();
    stepCycle();
  endtask

  task automatic streamRandom(input int n);
    int sent = 0;
    while (sent < n || rdIdx != wrIdx) begin
      outReady = (rnd32() % 4) != 0;
      if (!inValid || lastAcc) begin
        if (lastAcc) sent++;
        inValid = (sent < n) && (rnd32() % 3 != 0);
        inState = rnd128();
        inKey   = rnd128();
        inLast  = (sent == n - 1);
      end
      stepCycle();
    end
    inValid = 1'b0;
    stepCycle();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    logic [31:0]  kw [36];
    logic [31:0]  fk [4];
    logic [31:0]  s;
    logic [31:0]  ck;
    logic [127:0] st;
    logic [127:0] keyA;
    logic [127:0] keyB;

    for (int t = 0; t < 256; t++) begin
      logic [7:0] a;
      logic [7:0] inv;
      a = bAff(8'(t));
      inv = 8'h00;
      for (int y = 1; y < 256; y++) if (bMul(a, 8'(y)) == 8'h01) inv = 8'(y);
      sboxT[t] = bAff(inv);
    end

    fk[0] = 32'hA3B1BAC6; fk[1] = 32'h56AA3350; fk[2] = 32'h677D9197; fk[3] = 32'hB27022DC;
    kw[0] = 32'h01234567 ^ fk[0]; kw[1] = 32'h89ABCDEF ^ fk[1];
    kw[2] = 32'hFEDCBA98 ^ fk[2]; kw[3] = 32'h76543210 ^ fk[3];
    for (int i = 0; i < 32; i++) begin
      ck = {8'((4*i)*7), 8'((4*i+1)*7), 8'((4*i+2)*7), 8'((4*i+3)*7)};
      s = tauB(kw[i+1] ^ kw[i+2] ^ kw[i+3] ^ ck);
      kw[i+4] = kw[i] ^ s ^ rol(s, 13) ^ rol(s, 23);
      rkSched[i] = kw[i+4];
    end

    // R11 reset state
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R11 outValid in reset", 128'(outValid), 128'd0);
    check(errFlag == 1'b0, "R11 errFlag in reset", 128'(errFlag), 128'd0);
    check(outLast == 1'b0, "R11 outLast in reset", 128'(outLast), 128'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0 && errFlag == 1'b0, "R11 state after reset", {outValid, errFlag}, 128'd0);
    check(inReady == 1'b1, "R6 ready when empty", 128'(inReady), 128'd1);

    // R1 R2 R3: eight chained per-group operations on the standard vector
    modeBcast = 1'b0;
    outReady  = 1'b1;
    st = 128'h76543210_FEDCBA98_89ABCDEF_01234567;
    for (int op = 0; op < 8; op++) begin
      sendBeat(st, {rkSched[4*op+3], rkSched[4*op+2], rkSched[4*op+1], rkSched[4*op]}, op == 7);
      while (rdIdx != wrIdx) stepCycle();
      st = lastPop;
    end
    check(st == 128'h681EDF34_D206965E_86B3E94F_536E4246, "R1 standard ciphertext",
          st, 128'h681EDF34_D206965E_86B3E94F_536E4246);

    // R3 random per-group beats with backpressure
    streamRandom(12);

    // R4 R5: broadcast key load while a beat is offered, then a random stream
    modeBcast = 1'b1;
    keyA = rnd128();
    keyLoad = 1'b1;
    keyIn = keyA;
    inState = rnd128();
    inKey = rnd128();
    inLast = 1'b0;
    inValid = 1'b1;
    stepCycle();
    check(lastAcc == 1'b0, "R5 beat taken during keyLoad", 128'(lastAcc), 128'd0);
    keyLoad = 1'b0;
    inValid = 1'b0;
    streamRandom(20);

    // R4 key replacement
    keyB = rnd128();
    keyLoad = 1'b1;
    keyIn = keyB;
    stepCycle();
    keyLoad = 1'b0;
    streamRandom(8);

    // R9 R10: illegal key load and illegal beats
    cfgIllegal = 1'b1;
    keyLoad = 1'b1;
    keyIn = rnd128();
    stepCycle();
    keyLoad = 1'b0;
    check(errFlag == 1'b1, "R10 errFlag after illegal keyLoad", 128'(errFlag), 128'd1);
    outReady = 1'b1;
    for (int b = 0; b < 3; b++) sendBeat(rnd128(), rnd128(), b == 2);
    for (int c = 0; c < 4; c++) begin
      check(outValid == 1'b0, "R9 output after illegal beat", 128'(outValid), 128'd0);
      stepCycle();
    end
    cfgIllegal = 1'b0;

    // R10 stored key untouched by the illegal load; flag stays high
    sendBeat(rnd128(), rnd128(), 1'b0);
    sendBeat(rnd128(), rnd128(), 1'b1);
    drain();
    check(errFlag == 1'b1, "R10 errFlag sticky", 128'(errFlag), 128'd1);
    check(bKey == keyB, "R10 bench key tracking", bKey, keyB);

    // R3 back to per-group mode
    modeBcast = 1'b0;
    streamRandom(6);

    // R11 reset clears the flag
    rstN = 1'b0;
    @(negedge clk);
    check(errFlag == 1'b0 && outValid == 1'b0, "R11 reset clears flag", {errFlag, outValid}, 128'd0);
    rstN = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule